// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that requests a system reset when software stops servicing it. Software reaches it through a small register bus with two byte-wide locations. A control location selects the timeout period, turns on window mode and chooses whether the count pauses while a debugger holds the processor. A service location takes the keep-alive sequence: an arming byte followed by a firing byte.

Outside special mode the period and window settings can be written once after reset and are then fixed, and that one write is used up even when it changes nothing. In special mode, which is meant for test and debug, the settings stay writable. With window mode on, servicing is accepted only in the last quarter of the period, and a service write that comes too early requests a reset in the same way a timeout does. The reset request is a single-cycle pulse. The count restarts after every request, so the block keeps running if the system does not reset it.

Top module: `wdt_window_guard`

## Requirements
- R1: After reset the control location reads 0x00, the reset request is low and the rate code is 000. While the rate code is 000 no timeout occurs and writes to the service location are ignored.
- R2: The control location (bus_addr 0) reads window enable in bit 7, debug-pause in bit 6 and the rate code in bits 2:0. Bits 5:3 read 0. Bit 5 is a write-only mask and is never stored.
- R3: With special_mode low, the first unmasked control write fixes window enable and the rate code until reset. A write of rate 000 or window 0 changes nothing but still uses up that write.
- R4: With special_mode high, window enable and the rate code can be rewritten at any time, and window enable can be cleared. A rate code of 000 still changes nothing.
- R5: A control write with bit 5 set leaves window enable and the rate code unchanged, does not restart the count and does not use up the single normal-mode write.
- R6: With special_mode low the debug-pause bit can only be set. With special_mode high it follows the written value. Each change of that bit from 0 to 1 restarts the count.
- R7: Rate code c (1 to 7) selects a period P of 2^(4+2c) cycles. reset_req goes high for exactly one cycle, P cycles after the cycle of the write that restarted the count. The count then starts again.
- R8: A control write that stores a nonzero rate code restarts the count.
- R9: While debug-pause is 1 and debug_active is high, the count holds. Each such cycle delays the timeout by one cycle.
- R10: Service bytes at bus_addr 1: 0x55 arms and may be repeated, and 0xAA after an arm restarts the count. 0xAA without an arm, or any other byte, requests a reset. reset_req is high in the cycle after the write, and the count restarts.
- R11: With window mode on, a service write made while the count is below 3P/4 requests a reset. Writes made at a count of 3P/4 or above are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | High selects the unrestricted configuration mode |
| debug_active | input | 1 | High while a debugger holds the system |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 1 | 0 selects control, 1 selects service |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| reset_req | output | 1 | Single-cycle reset request |

## Verification
The reset request is registered, so the result of a bad or early service write is expected in the cycle that follows the clock edge capturing the write. A timeout is expected exactly P cycles after the write that restarted the count, plus one cycle for each paused cycle. The driver records the cycle in which each write lands and pushes the predicted pulse cycle into a queue before it drives the stimulus. The monitor compares every observed pulse against the head of that queue half a cycle after the edge. Window boundaries are tested with writes placed at counts 3P/4-1 and 3P/4.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W   = 8;
    localparam int RATE_W   = 3;
    localparam int POS_WIN  = 7;
    localparam int POS_DBG  = 6;
    localparam int POS_MASK = 5;

    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_SVC = 1'b1;

    localparam logic [DATA_W-1:0] KEY_ARM  = 8'h55;
    localparam logic [DATA_W-1:0] KEY_FIRE = 8'hAA;

    typedef struct packed {
        logic              win_en;
        logic              dbg_stop;
        logic [RATE_W-1:0] rate;
    } wdt_cfg_t;

    typedef enum logic [1:0] {
        SVC_ARM,
        SVC_FIRE,
        SVC_BAD
    } svc_kind_t;

    function automatic svc_kind_t classify(input logic [DATA_W-1:0] d);
        if (d == KEY_ARM)
            return SVC_ARM;
        else if (d == KEY_FIRE)
            return SVC_FIRE;
        else
            return SVC_BAD;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_view(input wdt_cfg_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[POS_WIN]      = c.win_en;
        r[POS_DBG]      = c.dbg_stop;
        r[RATE_W-1:0]   = c.rate;
        return r;
    endfunction

endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              special_mode,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output wdt_cfg_t          cfg,
    output logic              restart
);

    wdt_cfg_t cfg_q, cfg_d;
    logic     locked_q, locked_d;
    logic     field_ok;
    logic     unused_rsvd;

    assign unused_rsvd = ^wdata[4:3];

    always_comb begin
        cfg_d    = cfg_q;
        locked_d = locked_q;
        restart  = 1'b0;
        field_ok = 1'b0;
        if (wr) begin
            field_ok = !wdata[POS_MASK] && (special_mode || !locked_q);
            if (field_ok) begin
                cfg_d.win_en = special_mode ? wdata[POS_WIN]
                                            : (cfg_q.win_en | wdata[POS_WIN]);
                if (wdata[RATE_W-1:0] != '0) begin
                    cfg_d.rate = wdata[RATE_W-1:0];
                    restart    = 1'b1;
                end
                if (!special_mode)
                    locked_d = 1'b1;
            end
            cfg_d.dbg_stop = special_mode ? wdata[POS_DBG]
                                          : (cfg_q.dbg_stop | wdata[POS_DBG]);
            if (!cfg_q.dbg_stop && cfg_d.dbg_stop)
                restart = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            cfg_q    <= cfg_d;
            locked_q <= locked_d;
        end
    end

    assign cfg = cfg_q;

    AST_LOCK_KEEPS_RATE: assert property (@(posedge clk) disable iff (rst)
        (locked_q && !special_mode) |=> ($stable(cfg_q.rate) && $stable(cfg_q.win_en))); // R3

    AST_MASK_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[POS_MASK]) |=> ($stable(cfg_q.rate) && $stable(locked_q))); // R5

    AST_DBG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.dbg_stop && !special_mode) |=> cfg_q.dbg_stop); // R6

endmodule

// File: rtl/wdt_period_counter.sv
module wdt_period_counter
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 6,
    parameter int STEP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate,
    input  logic              restart,
    input  logic              freeze,
    output logic              timeout,
    output logic              window_open
);

    localparam int RATE_MAX = (1 << RATE_W) - 1;
    localparam int CNT_W    = BASE_LOG2 + STEP_LOG2 * (RATE_MAX - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   period;
    logic [CNT_W-1:0] last_val;
    logic [CNT_W-1:0] win_start;
    logic             enabled;
    int               shift;

    always_comb begin
        enabled   = (rate != '0);
        shift     = enabled ? (BASE_LOG2 + STEP_LOG2 * (int'(rate) - 1)) : BASE_LOG2;
        period    = {{CNT_W{1'b0}}, 1'b1} << shift;
        last_val  = CNT_W'(period - 1'b1);
        win_start = CNT_W'(period - (period >> 2));
    end

    assign timeout     = enabled && !freeze && !restart && (cnt_q == last_val);
    assign window_open = enabled && (cnt_q >= win_start);

    always_ff @(posedge clk) begin
        if (rst || restart || !enabled)
            cnt_q <= '0;
        else if (!freeze)
            cnt_q <= timeout ? '0 : cnt_q + 1'b1;
    end

    AST_EXPIRY_ONCE: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout); // R7

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (freeze && !restart && enabled) |=> $stable(cnt_q)); // R9

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/wdt_service_seq.sv
module wdt_service_seq
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              enabled,
    input  logic              win_en,
    input  logic              window_open,
    input  logic              disarm,
    output logic              fault,
    output logic              kick
);

    svc_kind_t kind;
    logic      armed_q;
    logic      too_early;

    always_comb begin
        kind      = classify(wdata);
        too_early = win_en && !window_open;
        fault     = wr && enabled &&
                    (too_early || (kind == SVC_BAD) || (kind == SVC_FIRE && !armed_q));
        kick      = wr && enabled && !fault && (kind == SVC_FIRE);
    end

    always_ff @(posedge clk) begin
        if (rst || !enabled || disarm || fault || kick)
            armed_q <= 1'b0;
        else if (wr && kind == SVC_ARM)
            armed_q <= 1'b1;
    end

    AST_KICK_DISARMS: assert property (@(posedge clk) disable iff (rst)
        kick |=> !armed_q); // R10

endmodule

// File: rtl/wdt_window_guard.sv
module wdt_window_guard
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 6,
    parameter int STEP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              special_mode,
    input  logic              debug_active,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_req
);

    wdt_cfg_t cfg;
    logic     ctl_wr, svc_wr;
    logic     cfg_restart, cnt_restart;
    logic     timeout, window_open;
    logic     fault, kick;
    logic     freeze;
    logic     reset_req_q;

    assign ctl_wr = bus_wr && (bus_addr == ADDR_CTL);
    assign svc_wr = bus_wr && (bus_addr == ADDR_SVC);
    assign freeze = cfg.dbg_stop && debug_active;
    assign cnt_restart = cfg_restart || kick || fault;

    wdt_cfg_reg u_cfg (
        .clk          (clk),
        .rst          (rst),
        .special_mode (special_mode),
        .wr           (ctl_wr),
        .wdata        (bus_wdata),
        .cfg          (cfg),
        .restart      (cfg_restart)
    );

    wdt_period_counter #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2)
    ) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .rate        (cfg.rate),
        .restart     (cnt_restart),
        .freeze      (freeze),
        .timeout     (timeout),
        .window_open (window_open)
    );

    wdt_service_seq u_svc (
        .clk         (clk),
        .rst         (rst),
        .wr          (svc_wr),
        .wdata       (bus_wdata),
        .enabled     (cfg.rate != '0),
        .win_en      (cfg.win_en),
        .window_open (window_open),
        .disarm      (cfg_restart || timeout),
        .fault       (fault),
        .kick        (kick)
    );

    always_ff @(posedge clk) begin
        if (rst)
            reset_req_q <= 1'b0;
        else
            reset_req_q <= timeout || fault;
    end

    assign reset_req = reset_req_q;
    assign bus_rdata = (bus_addr == ADDR_CTL) ? cfg_view(cfg) : '0;

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cfg.rate == '0) |=> !reset_req); // R1

    AST_EARLY_SERVICE: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && cfg.rate != '0 && cfg.win_en && !window_open) |=> reset_req); // R11

    AST_BAD_KEY: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && cfg.rate != '0 && classify(bus_wdata) == SVC_BAD) |=> reset_req); // R10

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_CTL) |-> (bus_rdata[5:3] == 3'b000)); // R2

endmodule

// File: tb/tb_wdt_window_guard.sv
`timescale 1ns/1ps
module tb_wdt_window_guard;

    typedef struct {
        int unsigned at;
        string       tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       special_mode = 1'b0;
    logic       debug_active = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       reset_req;

    int unsigned cyc = 0;
    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    exp_t        exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_window_guard dut (
        .clk          (clk),
        .rst          (rst),
        .special_mode (special_mode),
        .debug_active (debug_active),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .reset_req    (reset_req)
    );

    // Monitor: every pulse must match the head of the expectation queue.
    initial forever begin
        @(negedge clk);
        #2;
        if (!rst && reset_req) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected reset_req (R1 R5 R7): actual cycle %0d, expected none", cyc);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.at != cyc) begin
                    n_fail++;
                    $display("FAIL %s reset_req cycle: actual %0d, expected %0d", e.tag, cyc, e.at);
                end
            end
        end
    end

    task automatic expect_at(input int unsigned t, input string tag);
        exp_t e;
        e.at  = t;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic a, input logic [7:0] d, output int unsigned w);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        w      = cyc;
    endtask

    task automatic wait_to(input int unsigned t);
        while (cyc + 1 < t) @(negedge clk);
    endtask

    task automatic check_rd(input logic [7:0] exp, input string tag);
        bus_addr = 1'b0;
        #1;
        n_checks++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s control readback: actual %02h, expected %02h", tag, bus_rdata, exp);
        end
    endtask

    task automatic end_phase(input string tag);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s missing reset_req: actual none, expected cycle %0d",
                     exp_q[0].tag, exp_q[0].at);
            exp_q.delete();
        end
    endtask

    task automatic do_reset(input logic special);
        special_mode = special;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual hung run, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stimulus
        int unsigned w, w1, s, k, f, r, r2, f2;

        // Phase A: reset state, disabled watchdog, zero write uses the lock
        do_reset(1'b0);
        n_checks++;
        if (reset_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset_req after reset: actual %b, expected 0", reset_req);
        end
        check_rd(8'h00, "R1");
        repeat (100) @(negedge clk);
        wr(1'b1, 8'h12, w);                 // R1: service ignored while disabled
        repeat (50) @(negedge clk);
        wr(1'b0, 8'h00, w);                 // R3: no effect but locks
        wr(1'b0, 8'h02, w);
        check_rd(8'h00, "R3");
        repeat (200) @(negedge clk);
        end_phase("R1");

        // Phase B: period, ignored rewrite, service sequence, bare fire byte
        do_reset(1'b0);
        wr(1'b0, 8'h01, w);
        expect_at(w + 64, "R7");
        wr(1'b0, 8'h87, w1);                // R3: locked, no change, no restart
        check_rd(8'h01, "R3");
        wait_to(w + 100);
        wr(1'b1, 8'h55, s);
        wr(1'b1, 8'hAA, k);
        expect_at(k + 64, "R10");
        wait_to(k + 70);
        expect_at(cyc + 1, "R10");
        wr(1'b1, 8'hAA, w);
        repeat (5) @(negedge clk);
        end_phase("R7");

        // Phase C: masked write, window mode boundaries, bad byte
        do_reset(1'b0);
        wr(1'b0, 8'h23, w);                 // R5: masked, ignored, no lock
        check_rd(8'h00, "R5");
        wr(1'b0, 8'h81, w);
        check_rd(8'h81, "R2");
        wait_to(w + 10);
        expect_at(w + 10, "R11");
        wr(1'b1, 8'h55, f);
        wait_to(f + 50);
        wr(1'b1, 8'h55, s);
        wr(1'b1, 8'h55, s);
        wr(1'b1, 8'hAA, r);
        wait_to(r + 49);                    // R11: count 3P/4, first open cycle
        wr(1'b1, 8'h55, s);
        wr(1'b1, 8'hAA, r2);
        wait_to(r2 + 48);                   // R11: count 3P/4-1, still closed
        expect_at(r2 + 48, "R11");
        wr(1'b1, 8'h55, f2);
        wait_to(f2 + 55);
        expect_at(f2 + 55, "R10");
        wr(1'b1, 8'h33, w);
        repeat (3) @(negedge clk);
        end_phase("R11");

        // Phase D: special mode rewrites, restarts, mask
        do_reset(1'b1);
        wr(1'b0, 8'h01, w);
        wr(1'b0, 8'h02, w);                 // R8
        wr(1'b0, 8'h82, w);
        check_rd(8'h82, "R4");
        wr(1'b0, 8'h02, w);
        check_rd(8'h02, "R4");
        wr(1'b0, 8'h42, w);
        check_rd(8'h42, "R6");
        wr(1'b0, 8'h02, w1);
        check_rd(8'h02, "R6");
        expect_at(w1 + 256, "R8");
        wait_to(w1 + 100);
        wr(1'b0, 8'h23, w);                 // R5: no restart, rate kept
        check_rd(8'h02, "R5");
        wait_to(w1 + 260);
        end_phase("R8");

        // Phase E: debug pause in normal mode
        do_reset(1'b0);
        wr(1'b0, 8'h01, w);
        wr(1'b0, 8'h40, w1);                // R6: rising bit restarts
        check_rd(8'h41, "R6");
        expect_at(w1 + 64 + 30, "R9");
        repeat (10) @(negedge clk);
        debug_active = 1'b1;
        repeat (30) @(negedge clk);
        debug_active = 1'b0;
        wr(1'b0, 8'h00, w);                 // R6: cannot clear in normal mode
        check_rd(8'h41, "R6");
        wait_to(w1 + 100);
        end_phase("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule